// File: doc/BRIEF.md
# Overlapped Tile Broadcast Loader

This block spreads a host image over a two-dimensional array of processing elements (PEs). Each PE gets its own rectangular tile of the image, and neighbouring tiles may overlap by a programmable number of rows and columns. The host sends every pixel once, in raster order, on a single stream. The block places each pixel on a shared broadcast bus. In the same clock it raises the write enable of every PE whose tile contains that pixel, and it gives each of those PEs its own local write address.

A tile is `tileRows` x `tileCols` pixels. It is stored row by row in the PE's local memory, starting at the base address `baseAddr`. The tile of PE(r,c) starts at image row `r*stepRows` and image column `c*stepCols`. Vertical overlap is therefore `tileRows-stepRows` and horizontal overlap is `tileCols-stepCols`. A pixel that lies in no tile is accepted and then dropped.

The same block has two further commands. A readout command returns the tiles to the host in image raster order, without overlap: each pixel comes from the single PE that owns it. A constant command puts one value on the bus together with a destination-register code, so that every PE stores it. Configuration inputs must be held stable while `busy` is high.

Top module: `tile_bcast_loader`

## Requirements
- R1: After reset, `busy`, `bcastValid`, `outValid` and every bit of `peWrEn` are 0.
- R2: For each pixel (y,x) accepted during a load, `peWrEn` of PE(r,c), with index p = r*PE_COLS+c, is 1 in the cycle after acceptance exactly when r*stepRows <= y < r*stepRows+tileRows and c*stepCols <= x < c*stepCols+tileCols. Its address slice p is baseAddr + (y-r*stepRows)*tileCols + (x-c*stepCols), and `peWrData` carries the pixel.
- R3: A pixel that lies in several overlapping tiles is written to all of those PEs in the same single cycle.
- R4: A pixel that lies in no tile is consumed, raises no write enable, and still advances the raster position.
- R5: While loading, a cycle with `inValid` low produces no write and does not advance the raster position.
- R6: A load ends after exactly imgRows*imgCols accepted pixels. `busy` is 0 in the cycle after the last pixel is accepted.
- R7: A readout visits the image in raster order, one pixel per cycle. In each cycle it raises at most one `peRdEn`, for the PE with r = y div stepRows and c = x div stepCols, at address baseAddr + (y mod stepRows)*tileCols + (x mod stepCols). The data word the PE returns one cycle later appears on `outData` with `outValid` high.
- R8: During readout, a pixel that no PE owns (r >= PE_ROWS or c >= PE_COLS) is output as 0.
- R9: A constant command raises `bcastValid` for one cycle, one cycle after `start`, with `bcastData` = `constIn` and `bcastDest` = `constDest`.
- R10: `start` is ignored while `busy` is high.
- R11: `cmdOp` encoding: 0 = load, 1 = readout, 2 = constant, 3 = no operation. A start with code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| cmdOp | input | 2 | Command code |
| imgRows | input | DIM_W | Image height in pixels |
| imgCols | input | DIM_W | Image width in pixels |
| tileRows | input | DIM_W | Rows per PE tile |
| stepRows | input | DIM_W | Unique rows per PE (row stride) |
| tileCols | input | DIM_W | Columns per PE tile |
| stepCols | input | DIM_W | Unique columns per PE (column stride) |
| baseAddr | input | ADDR_W | First local address of the tile |
| constIn | input | DATA_W | Constant for broadcast |
| constDest | input | DEST_W | Destination-register code for the constant |
| inValid | input | 1 | Host pixel valid |
| inData | input | DATA_W | Host pixel |
| busy | output | 1 | Load or readout in progress |
| peWrEn | output | PE_ROWS*PE_COLS | Per-PE capture enable |
| peWrAddr | output | PE_ROWS*PE_COLS*ADDR_W | Per-PE local write address, slice p for PE p |
| peWrData | output | DATA_W | Broadcast pixel |
| peRdEn | output | PE_ROWS*PE_COLS | Per-PE readout enable |
| peRdAddr | output | PE_ROWS*PE_COLS*ADDR_W | Per-PE readout address |
| peRdData | input | PE_ROWS*PE_COLS*DATA_W | PE read data, valid one cycle after peRdEn |
| outValid | output | 1 | Readout pixel valid |
| outData | output | DATA_W | Readout pixel |
| bcastValid | output | 1 | Constant broadcast strobe |
| bcastData | output | DATA_W | Broadcast constant |
| bcastDest | output | DEST_W | Destination-register code |

## Verification
A wrong raster or stride counter shows up at the ports one cycle after the pixel where it goes wrong. From that pixel on, the write-enable pattern or an address slice no longer matches the arithmetic tiling, so each accepted pixel is compared as soon as its write is registered. A wrong counter that affects only stored contents, for example a slip on a row wrap, is caught by comparing every PE's modelled memory against the tile the PE should hold. A wrong ownership choice during readout shows as a wrong word in the raster output one cycle after the bad read enable.

// File: rtl/tile_ldr_pkg.sv
package tile_ldr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_READ = 2'd2
  } ldrState_t;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_CONST = 2'd2;

  typedef struct packed {
    logic loadStb;
    logic readStb;
    logic constStb;
  } ldrStrobe_t;

endpackage

// File: rtl/tile_ldr_ctrl.sv
module tile_ldr_ctrl
  import tile_ldr_pkg::*;
#(
  parameter int DIM_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cmdOp,
  input  logic [DIM_W-1:0] imgRows,
  input  logic [DIM_W-1:0] imgCols,
  input  logic [DIM_W-1:0] stepRows,
  input  logic [DIM_W-1:0] stepCols,
  input  logic             inValid,
  output ldrStrobe_t       strb,
  output logic [DIM_W-1:0] yCnt,
  output logic [DIM_W-1:0] xCnt,
  output logic [DIM_W-1:0] tileRowIdx,
  output logic [DIM_W-1:0] offRow,
  output logic [DIM_W-1:0] tileColIdx,
  output logic [DIM_W-1:0] offCol,
  output logic             busy
);

  ldrState_t state;
  logic      advance;
  logic      lastCol;
  logic      lastRow;
  logic      idleStart;

  assign idleStart = start && (state == ST_IDLE);
  assign advance   = ((state == ST_LOAD) && inValid) || (state == ST_READ);
  assign lastCol   = (xCnt == imgCols - DIM_W'(1));
  assign lastRow   = (yCnt == imgRows - DIM_W'(1));

  always_comb begin
    strb.loadStb  = (state == ST_LOAD) && inValid;
    strb.readStb  = (state == ST_READ);
    strb.constStb = idleStart && (cmdOp == OP_CONST);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      yCnt       <= '0;
      xCnt       <= '0;
      tileRowIdx <= '0;
      offRow     <= '0;
      tileColIdx <= '0;
      offCol     <= '0;
    end else if (idleStart) begin
      yCnt       <= '0;
      xCnt       <= '0;
      tileRowIdx <= '0;
      offRow     <= '0;
      tileColIdx <= '0;
      offCol     <= '0;
      if (cmdOp == OP_LOAD)      state <= ST_LOAD;
      else if (cmdOp == OP_READ) state <= ST_READ;
    end else if (advance) begin
      if (lastCol) begin
        xCnt       <= '0;
        offCol     <= '0;
        tileColIdx <= '0;
        if (lastRow) begin
          state <= ST_IDLE;
        end else begin
          yCnt <= yCnt + DIM_W'(1);
          if (offRow == stepRows - DIM_W'(1)) begin
            offRow     <= '0;
            tileRowIdx <= tileRowIdx + DIM_W'(1);
          end else begin
            offRow <= offRow + DIM_W'(1);
          end
        end
      end else begin
        xCnt <= xCnt + DIM_W'(1);
        if (offCol == stepCols - DIM_W'(1)) begin
          offCol     <= '0;
          tileColIdx <= tileColIdx + DIM_W'(1);
        end else begin
          offCol <= offCol + DIM_W'(1);
        end
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_LOAD) && !inValid && !start) |=> ($stable(xCnt) && $stable(yCnt))); // R5

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R10

  AST_X_IN_IMAGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (xCnt < imgCols)); // R6

endmodule

// File: rtl/tile_ldr_dp.sv
module tile_ldr_dp
  import tile_ldr_pkg::*;
#(
  parameter int PE_ROWS = 2,
  parameter int PE_COLS = 3,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int DIM_W   = 5,
  parameter int DEST_W  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ldrStrobe_t                  strb,
  input  logic [DIM_W-1:0]            yCnt,
  input  logic [DIM_W-1:0]            xCnt,
  input  logic [DIM_W-1:0]            tileRowIdx,
  input  logic [DIM_W-1:0]            offRow,
  input  logic [DIM_W-1:0]            tileColIdx,
  input  logic [DIM_W-1:0]            offCol,
  input  logic [DIM_W-1:0]            tileRows,
  input  logic [DIM_W-1:0]            stepRows,
  input  logic [DIM_W-1:0]            tileCols,
  input  logic [DIM_W-1:0]            stepCols,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [DATA_W-1:0]           inData,
  input  logic [DATA_W-1:0]           constIn,
  input  logic [DEST_W-1:0]           constDest,
  output logic [PE_ROWS*PE_COLS-1:0]        peWrEn,
  output logic [PE_ROWS*PE_COLS*ADDR_W-1:0] peWrAddr,
  output logic [DATA_W-1:0]                 peWrData,
  output logic [PE_ROWS*PE_COLS-1:0]        peRdEn,
  output logic [PE_ROWS*PE_COLS*ADDR_W-1:0] peRdAddr,
  input  logic [PE_ROWS*PE_COLS*DATA_W-1:0] peRdData,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic                        bcastValid,
  output logic [DATA_W-1:0]           bcastData,
  output logic [DEST_W-1:0]           bcastDest
);

  localparam int NPE = PE_ROWS * PE_COLS;
  localparam int EW  = 2 * DIM_W + ADDR_W + 2;

  logic             wrEnQ   [NPE];
  logic [ADDR_W-1:0] wrAddrQ [NPE];
  logic [NPE-1:0]   selQ;
  logic [ADDR_W-1:0] rdAddrC;

  assign rdAddrC = ADDR_W'(EW'(baseAddr) + EW'(offRow) * EW'(tileCols) + EW'(offCol));

  for (genvar r = 0; r < PE_ROWS; r++) begin : gRow
    for (genvar c = 0; c < PE_COLS; c++) begin : gCol
      localparam int P = r * PE_COLS + c;
      logic [EW-1:0] rowLo, colLo, rowOff, colOff;
      logic          rowHit, colHit;

      assign rowLo  = EW'(r) * EW'(stepRows);
      assign colLo  = EW'(c) * EW'(stepCols);
      assign rowHit = (EW'(yCnt) >= rowLo) && (EW'(yCnt) < rowLo + EW'(tileRows));
      assign colHit = (EW'(xCnt) >= colLo) && (EW'(xCnt) < colLo + EW'(tileCols));
      assign rowOff = EW'(yCnt) - rowLo;
      assign colOff = EW'(xCnt) - colLo;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          wrEnQ[P]   <= 1'b0;
          wrAddrQ[P] <= '0;
        end else begin
          wrEnQ[P] <= strb.loadStb && rowHit && colHit;
          if (strb.loadStb && rowHit && colHit)
            wrAddrQ[P] <= ADDR_W'(EW'(baseAddr) + rowOff * EW'(tileCols) + colOff);
        end
      end

      assign peWrEn[P]                     = wrEnQ[P];
      assign peWrAddr[P*ADDR_W +: ADDR_W]  = wrAddrQ[P];
      assign peRdEn[P]  = strb.readStb && (tileRowIdx == DIM_W'(r)) && (tileColIdx == DIM_W'(c));
      assign peRdAddr[P*ADDR_W +: ADDR_W]  = rdAddrC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      peWrData   <= '0;
      outValid   <= 1'b0;
      selQ       <= '0;
      bcastValid <= 1'b0;
      bcastData  <= '0;
      bcastDest  <= '0;
    end else begin
      if (strb.loadStb) peWrData <= inData;
      outValid   <= strb.readStb;
      selQ       <= peRdEn;
      bcastValid <= strb.constStb;
      if (strb.constStb) begin
        bcastData <= constIn;
        bcastDest <= constDest;
      end
    end
  end

  always_comb begin
    outData = '0;
    for (int p = 0; p < NPE; p++) begin
      if (selQ[p]) outData = outData | peRdData[p*DATA_W +: DATA_W];
    end
  end

  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(peRdEn)); // R7

  AST_WR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (|peWrEn) |-> $past(strb.loadStb)); // R2

  AST_OUT_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.readStb)); // R7

  AST_BCAST_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid |-> $past(strb.constStb)); // R9

  AST_NO_READ_DURING_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStb |-> (peRdEn == '0)); // R7

endmodule

// File: rtl/tile_bcast_loader.sv
module tile_bcast_loader
  import tile_ldr_pkg::*;
#(
  parameter int PE_ROWS = 2,
  parameter int PE_COLS = 3,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int DIM_W   = 5,
  parameter int DEST_W  = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [1:0]                        cmdOp,
  input  logic [DIM_W-1:0]                  imgRows,
  input  logic [DIM_W-1:0]                  imgCols,
  input  logic [DIM_W-1:0]                  tileRows,
  input  logic [DIM_W-1:0]                  stepRows,
  input  logic [DIM_W-1:0]                  tileCols,
  input  logic [DIM_W-1:0]                  stepCols,
  input  logic [ADDR_W-1:0]                 baseAddr,
  input  logic [DATA_W-1:0]                 constIn,
  input  logic [DEST_W-1:0]                 constDest,
  input  logic                              inValid,
  input  logic [DATA_W-1:0]                 inData,
  output logic                              busy,
  output logic [PE_ROWS*PE_COLS-1:0]        peWrEn,
  output logic [PE_ROWS*PE_COLS*ADDR_W-1:0] peWrAddr,
  output logic [DATA_W-1:0]                 peWrData,
  output logic [PE_ROWS*PE_COLS-1:0]        peRdEn,
  output logic [PE_ROWS*PE_COLS*ADDR_W-1:0] peRdAddr,
  input  logic [PE_ROWS*PE_COLS*DATA_W-1:0] peRdData,
  output logic                              outValid,
  output logic [DATA_W-1:0]                 outData,
  output logic                              bcastValid,
  output logic [DATA_W-1:0]                 bcastData,
  output logic [DEST_W-1:0]                 bcastDest
);

  ldrStrobe_t       strb;
  logic [DIM_W-1:0] yCnt, xCnt, tileRowIdx, offRow, tileColIdx, offCol;

  tile_ldr_ctrl #(.DIM_W(DIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdOp(cmdOp),
    .imgRows(imgRows), .imgCols(imgCols),
    .stepRows(stepRows), .stepCols(stepCols),
    .inValid(inValid), .strb(strb),
    .yCnt(yCnt), .xCnt(xCnt),
    .tileRowIdx(tileRowIdx), .offRow(offRow),
    .tileColIdx(tileColIdx), .offCol(offCol),
    .busy(busy)
  );

  tile_ldr_dp #(
    .PE_ROWS(PE_ROWS), .PE_COLS(PE_COLS), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .DEST_W(DEST_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .yCnt(yCnt), .xCnt(xCnt),
    .tileRowIdx(tileRowIdx), .offRow(offRow),
    .tileColIdx(tileColIdx), .offCol(offCol),
    .tileRows(tileRows), .stepRows(stepRows),
    .tileCols(tileCols), .stepCols(stepCols),
    .baseAddr(baseAddr), .inData(inData),
    .constIn(constIn), .constDest(constDest),
    .peWrEn(peWrEn), .peWrAddr(peWrAddr), .peWrData(peWrData),
    .peRdEn(peRdEn), .peRdAddr(peRdAddr), .peRdData(peRdData),
    .outValid(outValid), .outData(outData),
    .bcastValid(bcastValid), .bcastData(bcastData), .bcastDest(bcastDest)
  );

endmodule

// File: tb/sim_tile_bcast_loader.sv
module sim_tile_bcast_loader;
  localparam int CLK_PERIOD = 10;
  localparam int PR = 2, PC = 3, DW = 8, AW = 6, DMW = 5, DSW = 3;
  localparam int NPE = PR * PC;
  localparam int MEMD = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [DMW-1:0] imgRows = '0, imgCols = '0, tileRows = '0, stepRows = '0, tileCols = '0, stepCols = '0;
  logic [AW-1:0] baseAddr = '0;
  logic [DW-1:0] constIn = '0;
  logic [DSW-1:0] constDest = '0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic busy;
  logic [NPE-1:0] peWrEn, peRdEn;
  logic [NPE*AW-1:0] peWrAddr, peRdAddr;
  logic [DW-1:0] peWrData, outData, bcastData;
  logic [NPE*DW-1:0] peRdData;
  logic outValid, bcastValid;
  logic [DSW-1:0] bcastDest;

  logic [DW-1:0] mem [NPE][MEMD];
  logic clearMem = 1'b0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_bcast_loader #(.PE_ROWS(PR), .PE_COLS(PC), .DATA_W(DW), .ADDR_W(AW),
                      .DIM_W(DMW), .DEST_W(DSW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cmdOp(cmdOp),
    .imgRows(imgRows), .imgCols(imgCols), .tileRows(tileRows), .stepRows(stepRows),
    .tileCols(tileCols), .stepCols(stepCols), .baseAddr(baseAddr),
    .constIn(constIn), .constDest(constDest), .inValid(inValid), .inData(inData),
    .busy(busy), .peWrEn(peWrEn), .peWrAddr(peWrAddr), .peWrData(peWrData),
    .peRdEn(peRdEn), .peRdAddr(peRdAddr), .peRdData(peRdData),
    .outValid(outValid), .outData(outData),
    .bcastValid(bcastValid), .bcastData(bcastData), .bcastDest(bcastDest)
  );

  // PE local memory model: write on enable, registered read
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPE; p++) begin
      if (clearMem) begin
        for (int a = 0; a < MEMD; a++) mem[p][a] <= '0;
      end else if (peWrEn[p]) begin
        mem[p][peWrAddr[p*AW +: AW]] <= peWrData;
      end
      if (peRdEn[p]) peRdData[p*DW +: DW] <= mem[p][peRdAddr[p*AW +: AW]];
    end
  end

  function automatic logic [DW-1:0] pix(int y, int x);
    return DW'(y * 16 + x + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic setCfg(int h, int w, int nr, int sr, int nc, int sc, int ma);
    imgRows = DMW'(h); imgCols = DMW'(w);
    tileRows = DMW'(nr); stepRows = DMW'(sr);
    tileCols = DMW'(nc); stepCols = DMW'(sc);
    baseAddr = AW'(ma);
  endtask

  task automatic wipe();
    @(negedge clk); clearMem = 1'b1;
    @(negedge clk); clearMem = 1'b0;
  endtask

  task automatic pulseStart(logic [1:0] op);
    @(negedge clk); start = 1'b1; cmdOp = op;
    @(posedge clk); @(negedge clk); start = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic loadImage(int h, int w, int nr, int sr, int nc, int sc, int ma, bit probeStart);
    setCfg(h, w, nr, sr, nc, sc, ma);
    wipe();
    pulseStart(2'd0);
    check(busy == 1'b1, "R6 busy after load start", int'(busy), 1);
    if (probeStart) begin
      // R10: constant command while busy must not broadcast
      start = 1'b1; cmdOp = 2'd2; constIn = 8'h3C;
      @(posedge clk); @(negedge clk); start = 1'b0; cmdOp = 2'd0;
      check(bcastValid == 1'b0 && busy == 1'b1, "R10 start ignored while busy", int'(bcastValid), 0);
    end
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        if (((y * w + x) % 4) == 3) begin
          inValid = 1'b0;
          @(posedge clk); @(negedge clk);
          check(peWrEn == '0, "R5 no write on idle input", int'(peWrEn), 0);
        end
        inValid = 1'b1; inData = pix(y, x);
        @(posedge clk); @(negedge clk);
        inValid = 1'b0;
        begin
          logic [NPE-1:0] expEn;
          int nHit;
          bit addrOk;
          expEn = '0; nHit = 0; addrOk = 1'b1;
          for (int r = 0; r < PR; r++) begin
            for (int c = 0; c < PC; c++) begin
              if (y >= r*sr && y < r*sr+nr && x >= c*sc && x < c*sc+nc) begin
                expEn[r*PC+c] = 1'b1; nHit++;
                if (int'(peWrAddr[(r*PC+c)*AW +: AW]) != ma + (y-r*sr)*nc + (x-c*sc)) addrOk = 1'b0;
              end
            end
          end
          if (nHit == 0)
            check(peWrEn == '0, "R4 uncovered pixel dropped", int'(peWrEn), 0);
          else if (nHit > 1)
            check(peWrEn == expEn && addrOk, "R3 overlap written in one slot", int'(peWrEn), int'(expEn));
          else
            check(peWrEn == expEn && addrOk, "R2 single tile write", int'(peWrEn), int'(expEn));
          if (nHit > 0)
            check(peWrData == pix(y, x), "R2 broadcast data", int'(peWrData), int'(pix(y, x)));
          if (y == h-1 && x == w-1)
            check(busy == 1'b0, "R6 busy drops after last pixel", int'(busy), 0);
        end
      end
    end
    // whole-memory comparison against the arithmetic tiling
    @(negedge clk);
    for (int r = 0; r < PR; r++) begin
      for (int c = 0; c < PC; c++) begin
        int bad = 0;
        for (int i = 0; i < nr; i++) begin
          for (int j = 0; j < nc; j++) begin
            if (r*sr+i < h && c*sc+j < w)
              if (mem[r*PC+c][ma + i*nc + j] != pix(r*sr+i, c*sc+j)) bad++;
          end
        end
        check(bad == 0, "R2 PE tile contents", bad, 0);
      end
    end
  endtask

  task automatic readImage(int h, int w, int nr, int sr, int nc, int sc, int ma);
    int idx = 0;
    int guard = 0;
    int bad = 0;
    int badZero = 0;
    setCfg(h, w, nr, sr, nc, sc, ma);
    pulseStart(2'd1);
    while (idx < h*w && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (outValid) begin
        int y = idx / w;
        int x = idx % w;
        if (y < PR*sr && x < PC*sc) begin
          if (outData != pix(y, x)) begin
            bad++;
            $display("FAIL R7 readout pixel (%0d,%0d) actual=%0d expected=%0d", y, x, outData, pix(y, x));
          end
        end else if (outData != '0) begin
          badZero++;
          $display("FAIL R8 unowned pixel (%0d,%0d) actual=%0d expected=0", y, x, outData);
        end
        idx++;
      end
    end
    check(bad == 0, "R7 raster readout", bad, 0);
    check(badZero == 0, "R8 unowned pixels zero", badZero, 0);
    check(idx == h*w, "R7 readout count", idx, h*w);
    @(negedge clk);
    check(busy == 1'b0 && outValid == 1'b0, "R7 readout ends", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && bcastValid == 0 && outValid == 0 && peWrEn == '0,
          "R1 reset state", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11: code 3 does nothing
    pulseStart(2'd3);
    check(busy == 1'b0 && bcastValid == 1'b0, "R11 no-op code", int'(busy), 0);

    // R9: constant broadcast
    constIn = 8'hA5; constDest = 3'd5;
    pulseStart(2'd2);
    check(bcastValid == 1'b1 && bcastData == 8'hA5 && bcastDest == 3'd5,
          "R9 constant broadcast", int'(bcastData), 'hA5);
    @(negedge clk);
    check(bcastValid == 1'b0, "R9 single-cycle strobe", int'(bcastValid), 0);

    // overlapped load: 3x3 tiles, row stride 2, column stride 1
    loadImage(5, 7, 3, 2, 3, 1, 4, 1'b1);
    // different overlap: 2x4 tiles, row stride 1, column stride 2
    loadImage(3, 8, 2, 1, 4, 2, 9, 1'b0);
    // non-overlapped load then readout, with unowned border pixels
    loadImage(5, 7, 2, 2, 2, 2, 0, 1'b0);
    readImage(5, 7, 2, 2, 2, 2, 0);
    // non-overlapped with base offset, fully owned image
    loadImage(4, 6, 2, 2, 2, 2, 17, 1'b0);
    readImage(4, 6, 2, 2, 2, 2, 17);

    summary();
    $finish;
  end
endmodule